// File: doc/BRIEF.md
# Audio Link Outgoing Frame Serializer

This block is the controller-side transmitter of a serial audio link. On every bit clock it shifts one bit of the outgoing frame onto a single serial data line. At the start of each frame it raises a frame marker that stays high for the sixteen bits of the tag phase. Each frame carries a 16-bit tag word followed by twelve 20-bit slots.

The block builds the tag word itself from per-slot valid flags. Any slot whose flag is clear is sent as zeros. A frame starts when the frame-start enable is seen high while the serializer is idle. If the enable is still high during the final bit of a frame, the next frame follows with no gap. All payloads and flags are captured at the clock edge that starts a frame, so the upstream logic may change them freely while that frame is being sent.

Top module: `aclink_tx_framer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tag_phase` and `tx_bit` are both 0.
- R2: A rising `bit_clk` edge that samples `frame_en` high while idle starts a frame. From that edge on, one frame bit is presented per cycle, most significant bit first.
- R3: The tag word is defined as follows. Bit 15 is the OR of all six valid flags. Bits 14, 13, 12, 11 and 10 carry the flags for slots 1 to 5 (command address, command data, left PCM, right PCM, modem). Bit 3 carries the flag for slot 12 (I/O control). Bits 9 to 4 and bits 2 to 0 are always 0.
- R4: `tag_phase` is high for exactly the 16 cycles of the tag word and low for the remaining 240 cycles of the frame.
- R5: After the tag come slots 1 to 12, each 20 bits wide and sent MSB first, so a frame is 256 cycles long. The slots are, in order: 1 command address, 2 command data, 3 left PCM, 4 right PCM, 5 modem. Slots 6 to 11 are reserved and always zero. Slot 12 is I/O control.
- R6: A slot whose valid flag was clear at frame start is sent as 20 zero bits, whatever its payload input holds.
- R7: Payloads and valid flags are captured at the frame-start edge. Changes to them during the frame have no effect on the bits of that frame.
- R8: If `frame_en` is high at the edge that ends the last bit of a frame, a new frame starts immediately with freshly captured inputs. If `frame_en` is low at that edge, the block returns to idle.
- R9: Reset is synchronous and active-low. Asserting it mid-frame aborts the frame, and both outputs are 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_en | input | 1 | Frame-start enable, sampled while idle or in the last bit |
| cmd_addr_word | input | 20 | Slot 1 payload (command address) |
| cmd_addr_vld | input | 1 | Slot 1 valid flag |
| cmd_data_word | input | 20 | Slot 2 payload (command data) |
| cmd_data_vld | input | 1 | Slot 2 valid flag |
| pcm_l_word | input | 20 | Slot 3 payload (left PCM) |
| pcm_l_vld | input | 1 | Slot 3 valid flag |
| pcm_r_word | input | 20 | Slot 4 payload (right PCM) |
| pcm_r_vld | input | 1 | Slot 4 valid flag |
| modem_word | input | 20 | Slot 5 payload (modem) |
| modem_vld | input | 1 | Slot 5 valid flag |
| ioctl_word | input | 20 | Slot 12 payload (I/O control) |
| ioctl_vld | input | 1 | Slot 12 valid flag |
| tx_bit | output | 1 | Serial frame data, MSB first |
| tag_phase | output | 1 | Frame marker, high during the 16 tag bits |

## Verification
A vector table drives the serializer with several valid-flag sets, each with distinct payloads: all slots valid, none valid, single slots, and alternating flag patterns. The all-valid case shows that every slot lands at its own position. The none-valid and single-slot cases show that zero stuffing and the tag bits follow the individual flags, and are not simply a copy of the payload. Directed cases follow. One changes inputs mid-frame, which exposes any capture that is not frozen at frame start. One runs two frames back to back, which separates correct chaining from a gap or a stale capture. One asserts reset mid-frame to show the abort.

// File: rtl/aclink_pkg.sv
// Package: shared sizes and slot numbering for the audio link frame serializer.
// Assumes a frame of one tag slot followed by NUM_SLOTS-1 equal data slots.
package aclink_pkg;
    parameter int SLOT_W    = 20;   // width of each data slot
    parameter int TAG_W     = 16;   // width of the tag slot
    parameter int NUM_SLOTS = 13;   // tag slot plus data slots
    localparam int FRAME_LEN = TAG_W + (NUM_SLOTS - 1) * SLOT_W;
    localparam int IDX_W     = $clog2(NUM_SLOTS);
    localparam int BIT_W     = $clog2(SLOT_W);

    // slot numbers used by the frame layout
    localparam int SL_ANY       = 0;   // entry 0 of the valid vector holds "any valid"
    localparam int SL_CMD_ADDR  = 1;
    localparam int SL_CMD_DATA  = 2;
    localparam int SL_PCM_L     = 3;
    localparam int SL_PCM_R     = 4;
    localparam int SL_MODEM     = 5;
    localparam int SL_IOCTL     = 12;

    typedef logic [NUM_SLOTS-1:0][SLOT_W-1:0] slot_arr_t;
    typedef logic [NUM_SLOTS-1:0]             slot_vld_t;
endpackage

// File: rtl/frame_sequencer.sv
// Module: frame_sequencer
// Tracks the slot and bit position within the frame being sent and decides
// when a frame starts, chains or ends. Assumes bit_idx counts down so the
// MSB of each slot is sent first.
module frame_sequencer
    import aclink_pkg::*;
#(
    parameter int P_SLOT_W    = SLOT_W,
    parameter int P_TAG_W     = TAG_W,
    parameter int P_NUM_SLOTS = NUM_SLOTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_en,
    output logic             active,
    output logic             load,
    output logic [IDX_W-1:0] slot_idx,
    output logic [BIT_W-1:0] bit_idx
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(P_NUM_SLOTS - 1);
    localparam logic [BIT_W-1:0] TAG_TOP   = BIT_W'(P_TAG_W - 1);
    localparam logic [BIT_W-1:0] SLOT_TOP  = BIT_W'(P_SLOT_W - 1);
    localparam int               LEN       = P_TAG_W + (P_NUM_SLOTS - 1) * P_SLOT_W;
    localparam int               RUN_W     = $clog2(LEN) + 1;

    logic last_bit;

    // last_bit: final bit of the final slot is on the line
    assign last_bit = active && (slot_idx == LAST_SLOT) && (bit_idx == '0);
    // load: start a frame from idle or chain one after the last bit
    assign load = frame_en && (!active || last_bit);

    // position counters: reset, start, end or advance one bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            slot_idx <= '0;
            bit_idx  <= TAG_TOP;
        end else if (load) begin
            active   <= 1'b1;
            slot_idx <= '0;
            bit_idx  <= TAG_TOP;
        end else if (last_bit) begin
            active   <= 1'b0;
            slot_idx <= '0;
            bit_idx  <= TAG_TOP;
        end else if (active) begin
            if (bit_idx == '0) begin
                slot_idx <= slot_idx + 1'b1;
                bit_idx  <= SLOT_TOP;
            end else begin
                bit_idx  <= bit_idx - 1'b1;
            end
        end
    end

    // checker counter: cycles spent in the current frame
    logic [RUN_W-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || load) run_cnt <= '0;
        else if (active)    run_cnt <= run_cnt + 1'b1;
    end

    // R5: every frame lasts exactly the full frame length
    a_r5_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        last_bit |-> (run_cnt == RUN_W'(LEN - 1)));
    // R8: enable at the last bit chains straight into a new tag phase
    a_r8_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && frame_en) |=> (active && slot_idx == '0 && bit_idx == TAG_TOP));
    // R8: no enable at the last bit returns to idle
    a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !frame_en) |=> !active);
    // R2: enable while idle starts a frame on the next cycle
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && frame_en) |=> (active && slot_idx == '0));
endmodule

// File: rtl/slot_latch.sv
// Module: slot_latch
// Captures all slot payloads and valid flags at frame start, storing zeros
// for any slot whose flag is clear. Assumes load is a single-cycle strobe.
module slot_latch
    import aclink_pkg::*;
#(
    parameter int P_SLOT_W    = SLOT_W,
    parameter int P_NUM_SLOTS = NUM_SLOTS
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  load,
    input  logic [P_NUM_SLOTS-1:0][P_SLOT_W-1:0]  data_in,
    input  logic [P_NUM_SLOTS-1:0]                valid_in,
    output logic [P_NUM_SLOTS-1:0][P_SLOT_W-1:0]  data_q,
    output logic [P_NUM_SLOTS-1:0]                valid_q
);
    for (genvar g = 0; g < P_NUM_SLOTS; g++) begin : g_slot
        // per-slot capture with zero stuffing of untagged slots
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[g]  <= '0;
                valid_q[g] <= 1'b0;
            end else if (load) begin
                data_q[g]  <= valid_in[g] ? data_in[g] : '0;
                valid_q[g] <= valid_in[g];
            end
        end
    end

    // R7: captured frame contents stay frozen between loads
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(data_q) && $stable(valid_q)));
endmodule

// File: rtl/tag_builder.sv
// Module: tag_builder
// Forms the tag word from the captured valid flags. Entry 0 of the flag
// vector holds the "any slot valid" bit; data slot s maps to tag bit
// TAG_W-1-s; trailing positions beyond the slots are zero.
module tag_builder
    import aclink_pkg::*;
#(
    parameter int P_TAG_W     = TAG_W,
    parameter int P_NUM_SLOTS = NUM_SLOTS
) (
    input  logic [P_NUM_SLOTS-1:0] valid_q,
    output logic [P_TAG_W-1:0]     tag
);
    assign tag[P_TAG_W-1] = valid_q[0];
    for (genvar s = 1; s < P_NUM_SLOTS; s++) begin : g_tag
        assign tag[P_TAG_W-1-s] = valid_q[s];
    end
    assign tag[P_TAG_W-P_NUM_SLOTS-1:0] = '0;
endmodule

// File: rtl/bit_mux.sv
// Module: bit_mux
// Selects the serial bit for the current position: a tag bit during slot 0,
// otherwise the captured slot payload. Drives 0 while idle.
module bit_mux
    import aclink_pkg::*;
#(
    parameter int P_SLOT_W    = SLOT_W,
    parameter int P_TAG_W     = TAG_W,
    parameter int P_NUM_SLOTS = NUM_SLOTS
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 active,
    input  logic [IDX_W-1:0]                     slot_idx,
    input  logic [BIT_W-1:0]                     bit_idx,
    input  logic [P_TAG_W-1:0]                   tag,
    input  logic [P_NUM_SLOTS-1:0][P_SLOT_W-1:0] data_q,
    input  logic [P_NUM_SLOTS-1:0]               valid_q,
    output logic                                 sdo
);
    logic [P_SLOT_W-1:0] tag_ext;
    assign tag_ext = {{(P_SLOT_W-P_TAG_W){1'b0}}, tag};

    // serial bit select for the current frame position
    always_comb begin
        if (!active)             sdo = 1'b0;
        else if (slot_idx == '0) sdo = tag_ext[bit_idx];
        else                     sdo = data_q[slot_idx][bit_idx];
    end

    // R6: a slot flagged invalid sends only zeros
    a_r6_zero_stuff: assert property (@(posedge clk) disable iff (!rst_n)
        (active && slot_idx != '0 && !valid_q[slot_idx]) |-> !sdo);
    // R3: trailing reserved tag positions are sent as zero
    a_r3_tag_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (active && slot_idx == '0 && bit_idx < BIT_W'(P_TAG_W - P_NUM_SLOTS)) |-> !sdo);
    // R1: idle line is low
    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sdo);
endmodule

// File: rtl/aclink_tx_framer.sv
// Module: aclink_tx_framer (top)
// Controller-side outgoing frame serializer for a serial audio link. Maps
// the named slot inputs onto the slot array, captures them at frame start,
// and shifts tag plus slots out one bit per clock with a tag-phase marker.
// Assumes bit_clk is the link bit clock supplied from outside.
module aclink_tx_framer
    import aclink_pkg::*;
(
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              frame_en,
    input  logic [SLOT_W-1:0] cmd_addr_word,
    input  logic              cmd_addr_vld,
    input  logic [SLOT_W-1:0] cmd_data_word,
    input  logic              cmd_data_vld,
    input  logic [SLOT_W-1:0] pcm_l_word,
    input  logic              pcm_l_vld,
    input  logic [SLOT_W-1:0] pcm_r_word,
    input  logic              pcm_r_vld,
    input  logic [SLOT_W-1:0] modem_word,
    input  logic              modem_vld,
    input  logic [SLOT_W-1:0] ioctl_word,
    input  logic              ioctl_vld,
    output logic              tx_bit,
    output logic              tag_phase
);
    localparam int SR_W = $clog2(TAG_W) + 2;

    slot_arr_t        slot_data, data_q;
    slot_vld_t        slot_vld, valid_q;
    logic             any_vld;
    logic             active, load;
    logic [IDX_W-1:0] slot_idx;
    logic [BIT_W-1:0] bit_idx;
    logic [TAG_W-1:0] tag;

    // any data slot offered as valid
    assign any_vld = cmd_addr_vld | cmd_data_vld | pcm_l_vld | pcm_r_vld | modem_vld | ioctl_vld;

    // place named inputs into the slot array; reserved slots stay zero
    always_comb begin
        slot_data              = '0;
        slot_vld               = '0;
        slot_vld[SL_ANY]       = any_vld;
        slot_data[SL_CMD_ADDR] = cmd_addr_word;
        slot_vld[SL_CMD_ADDR]  = cmd_addr_vld;
        slot_data[SL_CMD_DATA] = cmd_data_word;
        slot_vld[SL_CMD_DATA]  = cmd_data_vld;
        slot_data[SL_PCM_L]    = pcm_l_word;
        slot_vld[SL_PCM_L]     = pcm_l_vld;
        slot_data[SL_PCM_R]    = pcm_r_word;
        slot_vld[SL_PCM_R]     = pcm_r_vld;
        slot_data[SL_MODEM]    = modem_word;
        slot_vld[SL_MODEM]     = modem_vld;
        slot_data[SL_IOCTL]    = ioctl_word;
        slot_vld[SL_IOCTL]     = ioctl_vld;
    end

    frame_sequencer u_seq (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .frame_en (frame_en),
        .active   (active),
        .load     (load),
        .slot_idx (slot_idx),
        .bit_idx  (bit_idx)
    );

    slot_latch u_latch (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .load     (load),
        .data_in  (slot_data),
        .valid_in (slot_vld),
        .data_q   (data_q),
        .valid_q  (valid_q)
    );

    tag_builder u_tag (
        .valid_q (valid_q),
        .tag     (tag)
    );

    bit_mux u_mux (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .active   (active),
        .slot_idx (slot_idx),
        .bit_idx  (bit_idx),
        .tag      (tag),
        .data_q   (data_q),
        .valid_q  (valid_q),
        .sdo      (tx_bit)
    );

    // frame marker: high while the tag slot is on the line
    assign tag_phase = active && (slot_idx == '0);

    // checker counter: length of the current marker run
    logic [SR_W-1:0] sync_run;
    always_ff @(posedge bit_clk) begin
        if (!rst_n)         sync_run <= '0;
        else if (tag_phase) sync_run <= sync_run + 1'b1;
        else                sync_run <= '0;
    end

    // R4: each marker run is exactly the tag width
    a_r4_marker_width: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $fell(tag_phase) |-> (sync_run == SR_W'(TAG_W)));
    // R4: the marker never outlasts the tag width
    a_r4_marker_cap: assert property (@(posedge bit_clk) disable iff (!rst_n)
        tag_phase |-> (sync_run < SR_W'(TAG_W)));
    // R9: reset leaves the line quiet
    a_r9_reset_quiet: assert property (@(posedge bit_clk)
        !rst_n |=> (!tag_phase && !tx_bit));
endmodule

// File: tb/tb_aclink_tx_framer.sv
`timescale 1ns/1ps
module tb_aclink_tx_framer;
    logic        bit_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        frame_en = 1'b0;
    logic [19:0] w [6];
    logic [5:0]  v;
    logic        tx_bit, tag_phase;
    int          n_chk = 0, n_bad = 0;
    logic [511:0] cap_d, cap_s;

    always #10 bit_clk = ~bit_clk;   // 50 MHz

    aclink_tx_framer dut (
        .bit_clk(bit_clk), .rst_n(rst_n), .frame_en(frame_en),
        .cmd_addr_word(w[0]), .cmd_addr_vld(v[0]),
        .cmd_data_word(w[1]), .cmd_data_vld(v[1]),
        .pcm_l_word(w[2]),    .pcm_l_vld(v[2]),
        .pcm_r_word(w[3]),    .pcm_r_vld(v[3]),
        .modem_word(w[4]),    .modem_vld(v[4]),
        .ioctl_word(w[5]),    .ioctl_vld(v[5]),
        .tx_bit(tx_bit), .tag_phase(tag_phase));

    // {valid flags (bit0 cmd addr .. bit5 io ctrl), payload base}
    localparam logic [25:0] VEC [8] = '{
        {6'h3F, 20'hA5C3F}, {6'h00, 20'hFFFFF}, {6'h20, 20'h5A5A5},
        {6'h01, 20'h8F0F1}, {6'h15, 20'h12345}, {6'h2A, 20'hEDCBA},
        {6'h3F, 20'h80001}, {6'h1E, 20'h0C0C0}};

    localparam logic [255:0] SYNC_EXP = {16'hFFFF, 240'b0};

    function automatic logic [19:0] pay(input logic [19:0] base, input int k);
        return base + 20'(k * 32'h0ABCD);
    endfunction

    // expected frame built from R3, R5, R6
    function automatic logic [255:0] exp_frame(input logic [5:0] vv, input logic [19:0] base);
        logic [255:0] f;
        f = '0;
        f[255 -: 16] = {|vv, vv[0], vv[1], vv[2], vv[3], vv[4], 6'b0, vv[5], 3'b0};
        for (int k = 0; k < 6; k++) begin
            int sn, off;
            sn  = (k < 5) ? k + 1 : 12;
            off = 16 + (sn - 1) * 20;
            f[255 - off -: 20] = vv[k] ? pay(base, k) : 20'b0;
        end
        return f;
    endfunction

    task automatic set_in(input logic [5:0] vv, input logic [19:0] base);
        v = vv;
        for (int k = 0; k < 6; k++) w[k] = pay(base, k);
    endtask

    task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // sample one bit per cycle at negedge; returns at the negedge after the last edge
    task automatic capture(input int nbits);
        for (int i = 0; i < nbits; i++) begin
            cap_d = {cap_d[510:0], tx_bit};
            cap_s = {cap_s[510:0], tag_phase};
            @(negedge bit_clk);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, {254'b0, tag_phase, tx_bit}, 256'b0);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        set_in(6'h00, 20'h0);
        repeat (3) @(negedge bit_clk);
        rst_n = 1'b1;
        // R1: idle after reset, no start without enable
        repeat (10) @(negedge bit_clk);
        check_idle("R1 idle after reset");

        // table walk: R2 R3 R4 R5 R6
        for (int n = 0; n < 8; n++) begin
            set_in(VEC[n][25:20], VEC[n][19:0]);
            frame_en = 1'b1;
            @(negedge bit_clk);
            frame_en = 1'b0;
            capture(256);
            check("R4 marker pattern", cap_s[255:0], SYNC_EXP);
            check("R2/R3/R5/R6 frame bits", cap_d[255:0], exp_frame(VEC[n][25:20], VEC[n][19:0]));
            check_idle("R8 idle after frame");
            repeat (2) @(negedge bit_clk);
        end

        // R7: inputs change mid-frame
        set_in(6'h2D, 20'h3C3C3);
        frame_en = 1'b1;
        @(negedge bit_clk);
        frame_en = 1'b0;
        for (int i = 0; i < 256; i++) begin
            if (i == 40) set_in(6'h12, 20'hF00F0);
            if (i == 200) set_in(6'h3F, 20'h11111);
            cap_d = {cap_d[510:0], tx_bit};
            cap_s = {cap_s[510:0], tag_phase};
            @(negedge bit_clk);
        end
        check("R7 capture frozen", cap_d[255:0], exp_frame(6'h2D, 20'h3C3C3));

        // R8: back-to-back frames with new capture at chain point
        repeat (3) @(negedge bit_clk);
        set_in(6'h3F, 20'h6789A);
        frame_en = 1'b1;
        @(negedge bit_clk);
        for (int i = 0; i < 512; i++) begin
            if (i == 100) set_in(6'h09, 20'h2468A);
            if (i == 300) frame_en = 1'b0;
            cap_d = {cap_d[510:0], tx_bit};
            cap_s = {cap_s[510:0], tag_phase};
            @(negedge bit_clk);
        end
        check("R8 first chained frame", cap_d[511:256], exp_frame(6'h3F, 20'h6789A));
        check("R8 second chained frame", cap_d[255:0], exp_frame(6'h09, 20'h2468A));
        check("R4/R8 chained markers", cap_s[511:256] & cap_s[255:0], SYNC_EXP);
        check_idle("R8 idle after chain");

        // R9: reset mid-frame aborts
        set_in(6'h3F, 20'hFFFFF);
        frame_en = 1'b1;
        @(negedge bit_clk);
        frame_en = 1'b0;
        capture(30);
        rst_n = 1'b0;
        @(negedge bit_clk);
        check_idle("R9 abort on reset");
        repeat (2) @(negedge bit_clk);
        rst_n = 1'b1;
        repeat (3) @(negedge bit_clk);
        check_idle("R9 quiet after reset release");

        // R1/R6: none-valid frame with noisy payloads sends all zeros after empty tag
        set_in(6'h00, 20'hABCDE);
        frame_en = 1'b1;
        @(negedge bit_clk);
        frame_en = 1'b0;
        capture(256);
        check("R6 all slots stuffed", cap_d[255:0], 256'b0);
        check("R4 marker with empty frame", cap_s[255:0], SYNC_EXP);

        finish_run();
    end
endmodule